// File: doc/BRIEF.md
# General-Purpose Bidirectional I/O Port

This block is one general-purpose I/O port of eight pins, set up through three registers on a small register bus. The registers are a per-pin direction register, an output latch, and a read-only view of the pin levels. The pad is modelled as three vectors: an output enable, an output value and an input level. A pin whose direction bit selects output drives its latch bit onto the pad. A pin whose direction bit selects input leaves the pad undriven.

Software can read the pins and the latch separately. Pin levels pass through a two-flop synchronizer before they reach the read path. A read-modify-write sequence works from the latch, so it keeps the values that software wrote even when an input pin, or a loaded output pin, shows a different level. A per-pin override lets an attached peripheral take a pin away from general I/O. While the override is on, the peripheral sets both the drive enable and the driven value, and the direction and latch bits for that pin have no effect. They keep their contents for the time the override ends.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register holds 0xFF (every pin an input), the latch holds 0x00 and every padOe bit is 0.
- R2: With no override on a pin, a direction bit of 0 makes that pin an output (padOe bit 1, padOut bit equal to the latch bit), and a direction bit of 1 makes it an input (padOe bit 0).
- R3: Reading address 0 returns the pad input levels delayed by two clock edges through the synchronizer. A level change is not visible one edge after it occurs and is visible two edges after it occurs.
- R4: Reading address 1 returns the latch contents, not the pin levels, even when the two differ.
- R5: A write to address 0 or to address 1 loads busWdata into the latch on the next clock edge.
- R6: A write to address 2 loads busWdata into the direction register, and reading address 2 returns it.
- R7: While perEn bit i is 1, padOe bit i equals perOe bit i and padOut bit i equals perOut bit i, whatever the direction and latch bits hold, and those register bits are left unchanged.
- R8: Address 3 reads as 0x00, and a write to it changes neither the latch nor the direction register.
- R9: When busWe is 0, neither the latch nor the direction register changes, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 unused |
| busWe | input | 1 | Write strobe, taken at the clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, valid in the same cycle |
| perEn | input | 8 | Per-pin peripheral override enable |
| perOe | input | 8 | Drive enable a peripheral applies while it overrides a pin |
| perOut | input | 8 | Value a peripheral drives while it overrides a pin |
| padIn | input | 8 | Level seen at each pad |
| padOe | output | 8 | Pad drive enable, 1 drives the pad |
| padOut | output | 8 | Pad drive value |

## Verification
The bench sweeps all 256 direction patterns and all 256 override-enable patterns. A pad model feeds the driven value back on output pins and an external level on input pins. The sweeps catch an inverted direction sense, a pin that leaks its latch value while it should be an input, and an override that loses out to the direction bits. Latch readback is checked with input pins held opposite to the latch; a design that returned pin levels on the latch address would show the external value there. The synchronizer depth is checked one edge and two edges after a level change, which catches a missing or extra stage. Writes through both latch aliases, to the unused address and with the write strobe low are each followed by a readback, so a decode that drops the alias or writes on a stray address shows a changed register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Read source selected from the bus address
  typedef enum logic [1:0] {
    SEL_PIN   = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    regSel_e rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output gpioStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(2);

  always_comb begin
    strobe.wrLatch = 1'b0;
    strobe.wrDir   = 1'b0;
    strobe.rdSel   = SEL_NONE;
    unique case (busAddr)
      A_PIN: begin
        strobe.rdSel   = SEL_PIN;
        strobe.wrLatch = busWe;   // pin address aliases the latch on writes
      end
      A_LATCH: begin
        strobe.rdSel   = SEL_LATCH;
        strobe.wrLatch = busWe;
      end
      A_DIR: begin
        strobe.rdSel = SEL_DIR;
        strobe.wrDir = busWe;
      end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] perEn,
  input  logic [WIDTH-1:0] perOe,
  input  logic [WIDTH-1:0] perOut,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] dirQ
);

  localparam logic [WIDTH-1:0] DIR_RST   = '1;  // all inputs
  localparam logic [WIDTH-1:0] LATCH_RST = '0;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] pinLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= LATCH_RST;
      dirQ   <= DIR_RST;
    end else begin
      if (strobe.wrLatch) latchQ <= busWdata;
      if (strobe.wrDir)   dirQ   <= busWdata;
    end
  end

  // Input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncQ[SYNC_STAGES-1];

  // Per-pin pad drive with peripheral precedence
  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pin
      always_comb begin
        if (perEn[p]) begin
          padOe[p]  = perOe[p];
          padOut[p] = perOut[p];
        end else begin
          padOe[p]  = ~dirQ[p];
          padOut[p] = latchQ[p];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_PIN:   busRdata = pinLevel;
      SEL_LATCH: busRdata = latchQ;
      SEL_DIR:   busRdata = dirQ;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  perEn,
  input  logic [WIDTH-1:0]  perOe,
  input  logic [WIDTH-1:0]  perOut,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);

  gpioStrobe_t      strobe;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .perEn    (perEn),
    .perOe    (perOe),
    .perOut   (perOut),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .latchQ   (latchQ),
    .dirQ     (dirQ)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  perEn,
  input logic [WIDTH-1:0]  perOe,
  input logic [WIDTH-1:0]  perOut,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  latchQ,
  input logic [WIDTH-1:0]  dirQ
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr <= ADDR_W'(1)) |=> (latchQ == $past(busWdata))); // R5

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(2)) |=> (dirQ == $past(busWdata))); // R6

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(latchQ) && $stable(dirQ))); // R9

  AST_SPARE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(3)) |=> ($stable(latchQ) && $stable(dirQ))); // R8

  AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ perOe) | (padOut ^ perOut)) & perEn) == '0); // R7

  AST_PIN_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && busAddr == ADDR_W'(0)) |-> (busRdata == $past(padIn, 2))); // R3

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .perEn    (perEn),
  .perOe    (perOe),
  .perOut   (perOut),
  .padIn    (padIn),
  .padOe    (padOe),
  .padOut   (padOut),
  .latchQ   (latchQ),
  .dirQ     (dirQ)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] perEn = '0, perOe = '0, perOut = '0;
  logic [7:0] padIn, padOe, padOut;
  logic [7:0] extLevel = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Pad model: driven pins read back their own value, others see the outside level
  assign padIn = (padOe & padOut) | (~padOe & extLevel);

  gpio_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .perEn(perEn),
    .perOe(perOe), .perOut(perOut), .padIn(padIn),
    .padOe(padOe), .padOut(padOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] latchVal;
    logic [7:0] dirVal;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    rd(2'd2, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 latch", v, 8'h00);

    // R2/R3 sweep of every direction pattern
    latchVal = 8'hA5; extLevel = 8'h3C;
    wr(2'd1, latchVal);
    for (int d = 0; d < 256; d++) begin
      wr(2'd2, 8'(d));
      check("R2 padOe", padOe, ~8'(d));
      check("R2 padOut on outputs", padOut & padOe, latchVal & ~8'(d));
      settle();
      rd(2'd0, v); check("R3 pin read", v, (latchVal & ~8'(d)) | (extLevel & 8'(d)));
    end

    // R4 latch read differs from pin read
    wr(2'd2, 8'hFF); wr(2'd1, 8'h5A); extLevel = 8'hFF; settle();
    rd(2'd1, v); check("R4 latch read", v, 8'h5A);
    rd(2'd0, v); check("R4 pin read", v, 8'hFF);

    // R3 synchronizer depth
    @(negedge clk); extLevel = 8'h0F;
    @(negedge clk); rd(2'd0, v); check("R3 one edge", v, 8'hFF);
    @(negedge clk); rd(2'd0, v); check("R3 two edges", v, 8'h0F);

    // R5 both latch aliases, R6 direction readback
    for (int k = 0; k < 256; k++) begin
      wr(2'(k & 1), 8'(k * 37 + 11));
      rd(2'd1, v); check("R5 latch write", v, 8'(k * 37 + 11));
    end
    for (int k = 0; k < 256; k += 17) begin
      wr(2'd2, 8'(k));
      rd(2'd2, v); check("R6 dir readback", v, 8'(k));
    end

    // R7 override sweep
    dirVal = 8'h0F; latchVal = 8'h66;
    wr(2'd2, dirVal); wr(2'd1, latchVal);
    perOe = 8'hF0; perOut = 8'h99;
    for (int e = 0; e < 256; e++) begin
      @(negedge clk); perEn = 8'(e);
      #1;
      check("R7 padOe", padOe, (perOe & 8'(e)) | (~dirVal & ~8'(e)));
      check("R7 padOut", padOut, (perOut & 8'(e)) | (latchVal & ~8'(e)));
    end
    rd(2'd1, v); check("R7 latch kept", v, latchVal);
    rd(2'd2, v); check("R7 dir kept", v, dirVal);
    @(negedge clk); perEn = 8'h00;
    #1 check("R7 release", padOe, ~dirVal);

    // R8 unused address
    wr(2'd3, 8'hC3);
    rd(2'd3, v); check("R8 read zero", v, 8'h00);
    rd(2'd1, v); check("R8 latch kept", v, latchVal);
    rd(2'd2, v); check("R8 dir kept", v, dirVal);

    // R9 no strobe
    @(negedge clk);
    busWe = 1'b0; busAddr = 2'd1; busWdata = 8'hFF;
    @(negedge clk); busAddr = 2'd2; busWdata = 8'h00;
    @(negedge clk);
    rd(2'd1, v); check("R9 latch kept", v, latchVal);
    rd(2'd2, v); check("R9 dir kept", v, dirVal);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule